// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 24-bit words built from three 8-bit lanes. Each lane has its own active-low select. A request carries a read/write flag, a word address, write data and a three-bit lane mask. The controller registers the request and plays out the RAM strobes cycle by cycle. For reads it returns the sampled word with a one-cycle valid pulse. The lanes left out of the access come back as zero.

Every strobe width is a cycle count. It is computed at elaboration as the ceiling of a nanosecond figure divided by the clock period. A write runs in three phases. In the setup phase the selects and data are applied. In the strobe phase write enable is held low. In the hold phase write enable is released first, so that it ends the write while data and selects stay put. A read keeps output enable and the selects low until the access time has passed. When a write follows a read, the controller waits a few bus-release cycles with nothing driven before the write starts. The data pad is split into an output value, a drive enable and an input value, and the tri-state buffer itself lives outside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, req_ready is 1, all three selects, write enable and output enable are 1, the drive enable is 0 and rd_valid is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the access is over. With default timing that is 5 cycles for a write that needs no turnaround and 5 cycles for a read. sram_addr holds the accepted address for the whole access.
- R3: A write is one setup cycle, then T_WE cycles with write enable low, then one hold cycle. In the setup cycle the selects are low, the data is driven and write enable is high. In the hold cycle write enable is high again while the selects and the driven data are unchanged. The driven data is the word captured at acceptance, so later changes on req_wdata have no effect.
- R4: Output enable is 1 throughout a write. The drive enable is never 1 while output enable is 0.
- R5: Mask bit i selects lane i, which is data bits 8i+7 down to 8i. Only selected lanes have their select driven low. Lanes outside the mask keep their stored contents across a write.
- R6: A read holds output enable and the selected lanes' selects low for T_RD cycles, with write enable high and the drive enable 0.
- R7: rd_valid is 1 for exactly one cycle, the cycle after the last output-enable-low cycle. rd_data then carries the selected lanes as sampled at the end of that last cycle, with unselected lanes zero.
- R8: A write accepted after a read, with no write in between, first spends T_TURN cycles with all selects high and nothing driven. The write setup cycle only starts after those cycles.
- R9: T_WE, T_RD and T_TURN are the ceilings of the write pulse, read access and bus release times over the clock period. At a 4 ns clock with 8, 10 and 5 ns they are 2, 3 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 24 | Write data |
| req_lanes | input | 3 | Lane mask, bit i = lane i |
| sram_addr | output | 19 | RAM address bus |
| sram_cs_n | output | 3 | Per-lane active-low selects |
| sram_we_n | output | 1 | Active-low write enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_oe | output | 1 | Data pad drive enable |
| sram_dq_out | output | 24 | Data driven to the RAM |
| sram_dq_in | input | 24 | Data sampled from the RAM |
| rd_data | output | 24 | Read result |
| rd_valid | output | 1 | One-cycle read result strobe |

## Verification
The hardest state to reach is a write that must wait for bus release. It needs a read to finish first, with no write between them, so that the turnaround path is taken. The stimulus therefore puts a read directly in front of every partial-lane write during the mask sweep. The bench then counts the cycles from acceptance to the fall of write enable and compares that with the no-turnaround case. A bus model with per-lane selects returns filler bytes on unselected lanes, which shows that zero-masking happens inside the controller. The model also flags any cycle where the pad is driven while output enable is low.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_TURN     = 3'd1,
      ST_WSETUP   = 3'd2,
      ST_WSTROBE  = 3'd3,
      ST_WHOLD    = 3'd4,
      ST_RACCESS  = 3'd5,
      ST_RCAPTURE = 3'd6
   } lane_state_e;

   // Ceiling division, at least one cycle.
   function automatic int cycles_for(input int span_ps, input int clk_ps);
      int c;
      c = (span_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_slice.sv
module sram_lane_slice #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              lane_on,
   input  logic              strobe_on,
   input  logic [LANE_W-1:0] wdata,
   input  logic              lane_q,
   input  logic              capture,
   input  logic [LANE_W-1:0] dq_in,
   output logic              cs_n,
   output logic [LANE_W-1:0] dq_out,
   output logic [LANE_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n   <= 1'b1;
         dq_out <= '0;
         rdata  <= '0;
      end else begin
         cs_n <= !(strobe_on && lane_on);
         if (accept)
            dq_out <= wdata;
         if (capture)
            rdata <= lane_q ? dq_in : '0;
      end
   end

   assert_cs_in_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> lane_q);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W         = 19,
   parameter int LANES          = 3,
   parameter int LANE_W         = 8,
   parameter int CLK_PS         = 4000,
   parameter int WE_PULSE_PS    = 8000,
   parameter int RD_ACCESS_PS   = 10000,
   parameter int BUS_RELEASE_PS = 5000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [LANES*LANE_W-1:0]  req_wdata,
   input  logic [LANES-1:0]         req_lanes,
   output logic [ADDR_W-1:0]        sram_addr,
   output logic [LANES-1:0]         sram_cs_n,
   output logic                     sram_we_n,
   output logic                     sram_oe_n,
   output logic                     sram_dq_oe,
   output logic [LANES*LANE_W-1:0]  sram_dq_out,
   input  logic [LANES*LANE_W-1:0]  sram_dq_in,
   output logic [LANES*LANE_W-1:0]  rd_data,
   output logic                     rd_valid
);
   localparam int DATA_W = LANES * LANE_W;
   localparam int T_WE   = cycles_for(WE_PULSE_PS, CLK_PS);
   localparam int T_RD   = cycles_for(RD_ACCESS_PS, CLK_PS);
   localparam int T_TURN = cycles_for(BUS_RELEASE_PS, CLK_PS);
   localparam int T_MAX  = max3(T_WE, T_RD, T_TURN);
   localparam int CNT_W  = $clog2(T_MAX + 1);

   if (ADDR_W < 1 || LANES < 1 || LANE_W < 1) begin : g_bad_shape
      $error("sram_lane_ctrl: widths and lane count must be positive");
   end
   if (CLK_PS < 1 || WE_PULSE_PS < 0 || RD_ACCESS_PS < 0 || BUS_RELEASE_PS < 0) begin : g_bad_time
      $error("sram_lane_ctrl: clock period must be positive, spans non-negative");
   end

   lane_state_e state_q, state_d;
   logic              accept;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_done;
   logic              rd_last_q;
   logic [LANES-1:0]  mask_q, mask_n;
   logic [DATA_W-1:0] wdata_n;
   logic              strobe_d, we_n_d, oe_n_d, drive_d, capture;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign mask_n    = accept ? req_lanes : mask_q;
   assign wdata_n   = req_wdata;
   assign capture   = (state_q == ST_RACCESS) && tmr_done;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE:
            if (req_valid) begin
               if (!req_write) begin
                  state_d  = ST_RACCESS;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(T_RD - 1);
               end else if (rd_last_q) begin
                  state_d  = ST_TURN;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(T_TURN - 1);
               end else begin
                  state_d  = ST_WSETUP;
               end
            end
         ST_TURN:
            if (tmr_done) state_d = ST_WSETUP;
         ST_WSETUP: begin
            state_d  = ST_WSTROBE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_WE - 1);
         end
         ST_WSTROBE:
            if (tmr_done) state_d = ST_WHOLD;
         ST_WHOLD:
            state_d = ST_IDLE;
         ST_RACCESS:
            if (tmr_done) state_d = ST_RCAPTURE;
         ST_RCAPTURE:
            state_d = ST_IDLE;
         default:
            state_d = ST_IDLE;
      endcase
   end

   // Strobe levels for the state being entered; registered so the pads see flops.
   always_comb begin
      strobe_d = (state_d == ST_WSETUP) || (state_d == ST_WSTROBE) ||
                 (state_d == ST_WHOLD)  || (state_d == ST_RACCESS);
      we_n_d   = (state_d != ST_WSTROBE);
      oe_n_d   = (state_d != ST_RACCESS);
      drive_d  = (state_d == ST_WSETUP) || (state_d == ST_WSTROBE) ||
                 (state_d == ST_WHOLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         rd_last_q  <= 1'b0;
         mask_q     <= '0;
         sram_addr  <= '0;
         sram_we_n  <= 1'b1;
         sram_oe_n  <= 1'b1;
         sram_dq_oe <= 1'b0;
         rd_valid   <= 1'b0;
      end else begin
         state_q    <= state_d;
         sram_we_n  <= we_n_d;
         sram_oe_n  <= oe_n_d;
         sram_dq_oe <= drive_d;
         rd_valid   <= capture;
         if (accept) begin
            mask_q    <= req_lanes;
            sram_addr <= req_addr;
         end
         if (state_d == ST_RCAPTURE)
            rd_last_q <= 1'b1;
         else if (state_d == ST_WSETUP)
            rd_last_q <= 1'b0;
      end
   end

   sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sram_lane_slice #(.LANE_W(LANE_W)) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .accept    (accept),
         .lane_on   (mask_n[i]),
         .strobe_on (strobe_d),
         .wdata     (wdata_n[i*LANE_W +: LANE_W]),
         .lane_q    (mask_q[i]),
         .capture   (capture),
         .dq_in     (sram_dq_in[i*LANE_W +: LANE_W]),
         .cs_n      (sram_cs_n[i]),
         .dq_out    (sram_dq_out[i*LANE_W +: LANE_W]),
         .rdata     (rd_data[i*LANE_W +: LANE_W])
      );
   end

   // Cycles since output enable was last low, saturating at T_TURN.
   logic [CNT_W-1:0] quiet_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         quiet_q <= CNT_W'(T_TURN);
      else if (!sram_oe_n)
         quiet_q <= '0;
      else if (quiet_q < CNT_W'(T_TURN))
         quiet_q <= quiet_q + 1'b1;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_cs_n == '1 && sram_we_n && sram_oe_n && !sram_dq_oe && !rd_valid));
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(sram_addr));
   assert_busy_on_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !req_ready);
   assert_data_under_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_dq_oe);
   assert_we_ends_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> ($stable(sram_cs_n) && sram_dq_oe));
   assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n);
   assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> sram_oe_n);
   assert_read_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (sram_we_n && !sram_dq_oe));
   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   assert_bus_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (quiet_q >= CNT_W'(T_TURN)));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;
   localparam int EXP_WE = 2, EXP_RD = 3, EXP_TURN = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic        req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [23:0] req_wdata = '0;
   logic [2:0]  req_lanes = '0;
   logic [AW-1:0] sram_addr;
   logic [2:0]  sram_cs_n;
   logic        sram_we_n, sram_oe_n, sram_dq_oe, rd_valid;
   logic [23:0] sram_dq_out, sram_dq_in, rd_data;

   logic [23:0] mem  [DEPTH];
   logic [23:0] refm [DEPTH];
   int checks = 0, fails = 0;
   int we_run = 0, oe_run = 0;
   bit done = 1'b0;
   bit last_rd = 1'b0;

   always #2 clk = ~clk;

   sram_lane_ctrl #(
      .ADDR_W(AW), .LANES(3), .LANE_W(8), .CLK_PS(4000),
      .WE_PULSE_PS(8000), .RD_ACCESS_PS(10000), .BUS_RELEASE_PS(5000)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_lanes(req_lanes), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_oe(sram_dq_oe),
      .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Bus model: selected lanes return stored bytes, others return filler 0xA5.
   always_comb begin
      for (int l = 0; l < 3; l++)
         sram_dq_in[l*8 +: 8] = (!sram_cs_n[l] && sram_we_n && !sram_oe_n)
                                ? mem[sram_addr][l*8 +: 8] : 8'hA5;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int l = 0; l < 3; l++)
            if (!sram_cs_n[l] && !sram_we_n)
               mem[sram_addr][l*8 +: 8] <= sram_dq_out[l*8 +: 8];
         if (sram_dq_oe && !sram_oe_n)
            check(1'b0, "R4 drive while output enable low", 32'(sram_dq_oe), 32'd0);
         if (!sram_we_n) we_run++;
         else if (we_run != 0) begin
            check(we_run == EXP_WE, "R9 write enable width", 32'(we_run), 32'(EXP_WE));
            we_run = 0;
         end
         if (!sram_oe_n) oe_run++;
         else if (oe_run != 0) begin
            check(oe_run == EXP_RD, "R6 output enable width", 32'(oe_run), 32'(EXP_RD));
            oe_run = 0;
         end
      end
   end

   function automatic logic [23:0] lane_mask(input logic [2:0] m);
      return {{8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
   endfunction

   task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [23:0] d,
                         input logic [2:0] m, output logic [23:0] rd);
      int n, we_at, val_at, done_at, turn;
      turn = (wr && last_rd) ? EXP_TURN : 0;
      rd = 24'hx; we_at = 0; val_at = 0; done_at = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = m;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_wdata = ~d; req_lanes = ~m; req_addr = ~a;
      n = 1;
      while (1) begin
         if (!sram_we_n && we_at == 0) we_at = n;
         if (rd_valid) begin val_at = n; rd = rd_data; end
         if (sram_cs_n != 3'b111)
            check(sram_addr == a, "R2 address held", 32'(sram_addr), 32'(a));
         if (wr && n <= turn)
            check(sram_cs_n == 3'b111 && !sram_dq_oe, "R8 turnaround idle",
                  {28'd0, sram_cs_n, sram_dq_oe}, 32'he);
         if (wr && n == turn + 1) begin
            check(sram_cs_n == ~m, "R5 write selects", 32'(sram_cs_n), 32'(~m));
            check(sram_we_n && sram_oe_n && sram_dq_oe, "R3 setup strobes",
                  {29'd0, sram_we_n, sram_oe_n, sram_dq_oe}, 32'h7);
            check(sram_dq_out == d, "R3 setup data", 32'(sram_dq_out), 32'(d));
         end
         if (wr && n == turn + 2 + EXP_WE) begin
            check(sram_we_n && sram_cs_n == ~m && sram_dq_oe && sram_dq_out == d,
                  "R3 hold cycle", {28'd0, sram_cs_n, sram_we_n}, {28'd0, ~m, 1'b1});
         end
         if (!wr && n == 1)
            check(!sram_oe_n && sram_we_n && !sram_dq_oe && sram_cs_n == ~m,
                  "R6 read strobes", {27'd0, sram_cs_n, sram_oe_n, sram_we_n},
                  {27'd0, ~m, 2'b01});
         if (req_ready) begin done_at = n; break; end
         if (n > 100) break;
         @(negedge clk);
         n++;
      end
      if (wr) begin
         check(we_at == turn + 2, "R8 write enable start", 32'(we_at), 32'(turn + 2));
         check(done_at == EXP_WE + 3 + turn, "R2 write busy", 32'(done_at), 32'(EXP_WE + 3 + turn));
         last_rd = 1'b0;
      end else begin
         check(val_at == EXP_RD + 1, "R7 valid cycle", 32'(val_at), 32'(EXP_RD + 1));
         check(done_at == EXP_RD + 2, "R2 read busy", 32'(done_at), 32'(EXP_RD + 2));
         last_rd = 1'b1;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   function automatic logic [23:0] pat(input int a);
      return 24'(a * 24'h0F1E2D) ^ 24'h5A5A5A;
   endfunction

   initial begin
      logic [23:0] r, exp;
      for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; refm[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(req_ready && sram_cs_n == 3'b111 && sram_we_n && sram_oe_n && !sram_dq_oe && !rd_valid,
            "R1 reset state", {26'd0, req_ready, sram_cs_n, sram_we_n, sram_oe_n}, 32'h3f);

      // Full-word writes everywhere, then full reads.
      for (int a = 0; a < DEPTH; a++) begin
         do_req(1'b1, AW'(a), pat(a), 3'b111, r);
         refm[a] = pat(a);
      end
      for (int a = 0; a < DEPTH; a++) begin
         do_req(1'b0, AW'(a), 24'h0, 3'b111, r);
         check(r == refm[a], "R7 full read", 32'(r), 32'(refm[a]));
      end

      // Partial writes, each preceded by a read so the turnaround path is taken.
      for (int a = 0; a < DEPTH; a++) begin
         logic [2:0] m;
         m = 3'((a % 7) + 1);
         do_req(1'b0, AW'(a ^ 1), 24'h0, 3'b111, r);
         do_req(1'b1, AW'(a), ~pat(a), m, r);
         refm[a] = (refm[a] & ~lane_mask(m)) | (~pat(a) & lane_mask(m));
      end

      // Masked reads over every mask value, then full reads for R5.
      for (int a = 0; a < DEPTH; a++) begin
         logic [2:0] m;
         m = 3'(a % 8);
         do_req(1'b0, AW'(a), 24'h0, m, r);
         exp = refm[a] & lane_mask(m);
         check(r == exp, "R7 masked read zero lanes", 32'(r), 32'(exp));
      end
      for (int a = 0; a < DEPTH; a++) begin
         do_req(1'b0, AW'(a), 24'h0, 3'b111, r);
         check(r == refm[a], "R5 unselected lanes preserved", 32'(r), 32'(refm[a]));
      end

      // Write with empty mask changes nothing.
      do_req(1'b1, AW'(3), 24'hFFFFFF, 3'b000, r);
      do_req(1'b0, AW'(3), 24'h0, 3'b111, r);
      check(r == refm[3], "R5 empty mask write", 32'(r), 32'(refm[3]));

      @(negedge clk);
      check(req_ready && sram_cs_n == 3'b111 && !sram_dq_oe, "R1 idle after traffic",
            {28'd0, req_ready, sram_cs_n}, 32'hf);
      finish_run();
   end

endmodule